// File: doc/BRIEF.md
# Dual-Rate Serial Baud Generator

This block turns the system bus clock into two independent rate enables, one for a serial transmitter and one for a serial receiver. Both enables come from a shared first-stage prescaler with a non-power-of-two factor (1, 3, 4 or 13). Each direction then has its own power-of-two divider, from 1 to 128. Each output is a single-cycle tick. Its period in bus clocks is the prescaler factor multiplied by that direction's divider factor.

A single 8-bit control register sets the rate. Writing it clears the prescaler counter and both divider counters, so the new rate starts from a clean phase. Shifting, framing, sampling and status are left to the serial engines that consume the ticks.

Top module: `sbg_top`

## Requirements
- R1: The control register holds three read/write fields: prescaler select in bits 7:6, transmit select in bits 5:3 and receive select in bits 2:0. `rd_data_o` returns the last written byte.
- R2: After reset the register reads 00h, and both ticks are high on every cycle.
- R3: The prescaler select maps 00, 01, 10 and 11 to the factors 1, 3, 4 and 13.
- R4: A transmit select value n (0 to 7) divides the prescaled rate by 2^n.
- R5: A receive select value n (0 to 7) divides the prescaled rate by 2^n, independently of the transmit select.
- R6: Each tick is high for one bus clock per period, and the period equals the prescaler factor times the divider factor.
- R7: A write restarts all counters. Count the first cycle after the write edge as cycle 0. The first tick of a direction with total factor T then falls in cycle T-1, and no partial period of the old setting appears.
- R8: A divider counter never exceeds its limit, and the prescaler counter never reaches its factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control register |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Current control register contents |
| tx_tick_o | output | 1 | Transmit rate tick |
| rx_tick_o | output | 1 | Receive rate tick |

## Verification
The assertions assume that the selects change only through a register write. That write clears the counters on the same edge, so no counter is ever compared against a smaller, newly loaded limit. The stimulus changes the configuration only through `wr_en_i`. It always leaves at least a full slowest period between writes, except in the deliberate mid-period rewrite case. The sweep covers every prescaler setting, and each one is paired with every transmit and receive select.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  localparam int unsigned PRE_SEL_W = 2;
  localparam int unsigned DIV_SEL_W = 3;
  localparam int unsigned PRE_CNT_W = 4;

  typedef struct packed {
    logic [PRE_SEL_W-1:0] pre;
    logic [DIV_SEL_W-1:0] tx;
    logic [DIV_SEL_W-1:0] rx;
  } sbg_ctrl_t;

  function automatic logic [PRE_CNT_W-1:0] pre_factor(input logic [PRE_SEL_W-1:0] sel);
    case (sel)
      2'd0:    pre_factor = 4'd1;
      2'd1:    pre_factor = 4'd3;
      2'd2:    pre_factor = 4'd4;
      default: pre_factor = 4'd13;
    endcase
  endfunction
endpackage

// File: rtl/sbg_prescaler.sv
module sbg_prescaler #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] factor_i,
  output logic             en_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = factor_i - 1'b1;
  assign en_o = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_o)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  a_r8_pre_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < factor_i);
  a_r7_pre_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/sbg_divider.sv
module sbg_divider #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   span;

  assign span   = {{CNT_W{1'b0}}, 1'b1} << sel_i;
  assign lim    = CNT_W'(span - 1'b1);
  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  a_r8_div_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
  a_r6_single_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && lim != '0 && !clr_i) |=> !tick_o);
endmodule

// File: rtl/sbg_top.sv
module sbg_top
  import sbg_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             tx_tick_o,
  output logic             rx_tick_o
);
  localparam int unsigned N_DIR = 2;

  sbg_ctrl_t ctrl_q;
  logic      pre_en;
  logic [DIV_SEL_W-1:0] dir_sel [N_DIR];
  logic [N_DIR-1:0]     dir_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= sbg_ctrl_t'(wr_data_i);
  end

  assign rd_data_o = REG_W'(ctrl_q);

  sbg_prescaler #(.CNT_W(PRE_CNT_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (wr_en_i),
    .factor_i (pre_factor(ctrl_q.pre)),
    .en_o     (pre_en)
  );

  assign dir_sel[0] = ctrl_q.tx;
  assign dir_sel[1] = ctrl_q.rx;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    sbg_divider #(.SEL_W(DIV_SEL_W)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (wr_en_i),
      .en_i   (pre_en),
      .sel_i  (dir_sel[d]),
      .tick_o (dir_tick[d])
    );
  end

  assign tx_tick_o = dir_tick[0];
  assign rx_tick_o = dir_tick[1];

  a_r1_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == $past(wr_data_i));
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));
  a_r7_tick_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[7:6] != 2'b00) |=> !tx_tick_o && !rx_tick_o);
endmodule

// File: tb/sbg_top_test.sv
module sbg_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tx_tick, rx_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sbg_top uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .tx_tick_o(tx_tick), .rx_tick_o(rx_tick)
  );

  function automatic int pfac(input int s);
    case (s)
      0: return 1;
      1: return 3;
      2: return 4;
      default: return 13;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // After write_reg returns we sit at the negedge of cycle 0.
  task automatic run_combo(input int p, input int t, input int r, input int cyc);
    int tt, tr, bad_t, bad_r, first_t, first_r;
    tt = pfac(p) * (1 << t);
    tr = pfac(p) * (1 << r);
    bad_t = 0; bad_r = 0; first_t = -1; first_r = -1;
    write_reg({p[1:0], t[2:0], r[2:0]});
    check(rd_data == {p[1:0], t[2:0], r[2:0]}, "R1", rd_data, {p[1:0], t[2:0], r[2:0]});
    for (int k = 0; k < cyc; k++) begin
      if (tx_tick != ((k + 1) % tt == 0)) bad_t++;
      if (rx_tick != ((k + 1) % tr == 0)) bad_r++;
      if (tx_tick && first_t < 0) first_t = k;
      if (rx_tick && first_r < 0) first_r = k;
      @(negedge clk);
    end
    check(bad_t == 0, p == 0 ? "R4" : "R3", bad_t, 0);
    check(bad_r == 0, "R5", bad_r, 0);
    check(first_t == tt - 1, "R7", first_t, tt - 1);
    check(first_r == tr - 1, "R6", first_r, tr - 1);
  endtask

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 8'h00, "R2", rd_data, 0);
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      if (!tx_tick || !rx_tick) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R2", bad, 0);

    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 8; s++) begin
        int mx;
        mx = pfac(p) * (1 << ((s > 7 - s) ? s : 7 - s));
        run_combo(p, s, 7 - s, 2 * mx + 1);
      end

    // R7: rewrite partway through a long period restarts the phase
    write_reg(8'b11_011_010);
    repeat (40) @(negedge clk);
    run_combo(3, 3, 2, 2 * 13 * 8 + 1);
    run_combo(1, 5, 5, 2 * 3 * 32 + 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule